// File: doc/BRIEF.md
# Bit-Serial Adder/Subtractor

This unit adds or subtracts two unsigned N-bit operands using one full-adder cell. The cell is used again for each bit position on successive clock cycles, so no ripple-carry chain is ever built. A start strobe loads both operands and the operation select. One bit per cycle then passes through the cell, least significant bit first.

The cell registers its sum and carry, so each result bit is written into an internal work vector one cycle after its index was applied. A final cycle catches the last bit. The result port and the flag are updated together only when the whole word is complete, and a one-cycle done pulse marks that update.

The block suits datapaths where area matters more than latency. An N-bit operation takes N+1 cycles from the accepted start edge to done.

Top module: `bitserial_addsub`

## Requirements
- R1: With sub_i = 0, the result is (a + b) mod 2^N, and flag_o is bit N of the true sum (the carry out).
- R2: With sub_i = 1, the result is (a - b) mod 2^N, and flag_o is 1 exactly when a < b as unsigned values (borrow; this is the default FLAG_AS_BORROW = 1 variant).
- R3: done_o is high for exactly one cycle. That cycle follows the (N+1)th rising edge after the edge that accepted the start.
- R4: result_o and flag_o change only at the edge that raises done_o, and hold their values at all other times.
- R5: A start_i pulse that arrives while busy_o is high is ignored. The running operation completes with its original operands and its original timing.
- R6: A start seen while busy_o is low is accepted, and busy_o is high in the following cycle. busy_o falls at the same edge that raises done_o.
- R7: After synchronous reset, result_o, flag_o, done_o and busy_o are all 0.
- R8: With N = 8, the operands 0x55 and 0xAA in add mode give 0xFF with flag_o = 0.
- R9: A start given in the cycle where done_o is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe; loads the operands when the unit is idle |
| sub_i | input | 1 | Operation select: 0 add, 1 subtract |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| result_o | output | WIDTH | Published result, frozen between done pulses |
| flag_o | output | 1 | Carry out (add) or borrow (subtract) |
| done_o | output | 1 | One-cycle pulse when result_o and flag_o update |
| busy_o | output | 1 | High while an operation is in progress |

## Verification
The bench builds one instance with WIDTH = 4 and runs every operand pair in both modes, which is 512 operations. That covers every carry and borrow chain, every wrap-around and every boundary value. A second instance at the default WIDTH = 8 runs the 0x55 + 0xAA reference case and a few carry-edge operands. At the smaller width, start strobes can also be injected during every busy cycle, and starts can be chained into the done cycle.

// File: rtl/bser_pkg.sv
package bser_pkg;
   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } bser_op_e;
endpackage

// File: rtl/bser_cell.sv
// One registered full-adder cell, shared by all bit positions.
module bser_cell
   import bser_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     load_i,   // operation accepted: preset carry
   input  bser_op_e op_i,     // mode used for the preset and inversion
   input  logic     step_i,   // process one bit this cycle
   input  logic     a_bit_i,
   input  logic     b_bit_i,
   output logic     sum_q_o,
   output logic     carry_q_o
);
   logic b_eff;
   logic sum_d;
   logic carry_d;

   always_comb begin
      b_eff   = b_bit_i ^ (op_i == OP_SUB);
      sum_d   = a_bit_i ^ b_eff ^ carry_q_o;
      carry_d = (a_bit_i & b_eff) | (carry_q_o & (a_bit_i ^ b_eff));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_q_o   <= 1'b0;
         carry_q_o <= 1'b0;
      end else if (load_i) begin
         sum_q_o   <= 1'b0;
         carry_q_o <= (op_i == OP_SUB);
      end else if (step_i) begin
         sum_q_o   <= sum_d;
         carry_q_o <= carry_d;
      end
   end
endmodule

// File: rtl/bser_seq.sv
// Index counter and busy/done sequencing.
module bser_seq #(
   parameter int WIDTH = 8,
   localparam int IW = $clog2(WIDTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          accept_i,
   output logic [IW-1:0] idx_o,
   output logic          step_o,   // cell consumes bit idx_o
   output logic          wr_o,     // previous bit is captured
   output logic          last_o,   // capture cycle, publish result
   output logic          busy_o,
   output logic          done_o
);
   localparam logic [IW-1:0] LAST_IDX = IW'(WIDTH);

   always_comb begin
      step_o = busy_o && (idx_o != LAST_IDX);
      wr_o   = busy_o && (idx_o != '0);
      last_o = busy_o && (idx_o == LAST_IDX);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_o  <= '0;
         busy_o <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (accept_i) begin
            idx_o  <= '0;
            busy_o <= 1'b1;
         end else if (busy_o) begin
            if (last_o) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
            end else begin
               idx_o <= idx_o + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/bser_collect.sv
// Work vector filled at position idx-1, and the frozen output register.
module bser_collect #(
   parameter int WIDTH = 8,
   parameter bit FLAG_AS_BORROW = 1'b1,
   localparam int IW = $clog2(WIDTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IW-1:0]    idx_i,
   input  logic             wr_i,
   input  logic             last_i,
   input  logic             sub_i,
   input  logic             sum_q_i,
   input  logic             carry_q_i,
   output logic [WIDTH-1:0] result_o,
   output logic             flag_o
);
   // the top bit is never stored: it comes straight from the cell
   logic [WIDTH-2:0] work_q;
   logic             flag_d;

   for (genvar i = 0; i < WIDTH - 1; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst) begin
            work_q[i] <= 1'b0;
         end else if (wr_i && (idx_i == IW'(i + 1))) begin
            work_q[i] <= sum_q_i;
         end
      end
   end

   if (FLAG_AS_BORROW) begin : g_borrow
      assign flag_d = sub_i ? ~carry_q_i : carry_q_i;
   end else begin : g_raw
      logic unused_sub;
      assign unused_sub = sub_i;
      assign flag_d     = carry_q_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         result_o <= '0;
         flag_o   <= 1'b0;
      end else if (last_i) begin
         result_o <= {sum_q_i, work_q};
         flag_o   <= flag_d;
      end
   end
endmodule

// File: rtl/bitserial_addsub.sv
module bitserial_addsub
   import bser_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter bit FLAG_AS_BORROW = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic             sub_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] result_o,
   output logic             flag_o,
   output logic             done_o,
   output logic             busy_o
);
   localparam int IW = $clog2(WIDTH + 1);

   if (WIDTH < 2) begin : g_bad_width
      $error("bitserial_addsub: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] a_q;
   logic [WIDTH-1:0] b_q;
   bser_op_e         op_q;
   logic             accept;
   logic [IW-1:0]    idx;
   logic             step;
   logic             wr;
   logic             last;
   logic             sum_q;
   logic             carry_q;
   logic             a_bit;
   logic             b_bit;

   assign accept = start_i && !busy_o;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q  <= '0;
         b_q  <= '0;
         op_q <= OP_ADD;
      end else if (accept) begin
         a_q  <= a_i;
         b_q  <= b_i;
         op_q <= bser_op_e'(sub_i);
      end
   end

   always_comb begin
      a_bit = 1'b0;
      b_bit = 1'b0;
      for (int i = 0; i < WIDTH; i++) begin
         if (idx == IW'(i)) begin
            a_bit = a_q[i];
            b_bit = b_q[i];
         end
      end
   end

   bser_seq #(.WIDTH(WIDTH)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .accept_i (accept),
      .idx_o    (idx),
      .step_o   (step),
      .wr_o     (wr),
      .last_o   (last),
      .busy_o   (busy_o),
      .done_o   (done_o)
   );

   bser_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .load_i    (accept),
      .op_i      (accept ? bser_op_e'(sub_i) : op_q),
      .step_i    (step),
      .a_bit_i   (a_bit),
      .b_bit_i   (b_bit),
      .sum_q_o   (sum_q),
      .carry_q_o (carry_q)
   );

   bser_collect #(.WIDTH(WIDTH), .FLAG_AS_BORROW(FLAG_AS_BORROW)) u_collect (
      .clk       (clk),
      .rst       (rst),
      .idx_i     (idx),
      .wr_i      (wr),
      .last_i    (last),
      .sub_i     (op_q == OP_SUB),
      .sum_q_i   (sum_q),
      .carry_q_i (carry_q),
      .result_o  (result_o),
      .flag_o    (flag_o)
   );
endmodule

// File: rtl/bitserial_addsub_chk.sv
module bitserial_addsub_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             start_i,
   input logic [WIDTH-1:0] result_o,
   input logic             flag_o,
   input logic             done_o,
   input logic             busy_o
);
   localparam int CW = $clog2(WIDTH + 4);
   localparam logic [CW-1:0] DONE_CNT = CW'(WIDTH + 2);

   // counts edges since the accepted start, for the latency window
   logic [CW-1:0] cnt;
   always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else if (start_i && !busy_o) cnt <= CW'(1);
      else if (busy_o) cnt <= cnt + 1'b1;
   end

   p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);
   p_done_latency_r3: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (cnt == DONE_CNT));
   p_result_frozen_r4: assert property (@(posedge clk) disable iff (rst)
      !done_o |-> ($stable(result_o) && $stable(flag_o)));
   p_busy_holds_r5: assert property (@(posedge clk) disable iff (rst)
      busy_o |=> (busy_o || done_o));
   p_accept_r6: assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy_o) |=> busy_o);
   p_busy_fall_r6: assert property (@(posedge clk) disable iff (rst)
      $fell(busy_o) |-> done_o);
   p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
      done_o |-> !busy_o);
endmodule

bind bitserial_addsub bitserial_addsub_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .start_i  (start_i),
   .result_o (result_o),
   .flag_o   (flag_o),
   .done_o   (done_o),
   .busy_o   (busy_o)
);

// File: tb/bitserial_addsub_test.sv
`timescale 1ns/1ps
module bitserial_addsub_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   int nchk  = 0;
   int nfail = 0;
   bit ended = 1'b0;

   logic       start4 = 1'b0, sub4 = 1'b0;
   logic [3:0] a4 = '0, b4 = '0, res4;
   logic       flag4, done4, busy4;

   logic       start8 = 1'b0, sub8 = 1'b0;
   logic [7:0] a8 = '0, b8 = '0, res8;
   logic       flag8, done8, busy8;

   bitserial_addsub #(.WIDTH(4)) uut (
      .clk(clk), .rst(rst), .start_i(start4), .sub_i(sub4),
      .a_i(a4), .b_i(b4), .result_o(res4), .flag_o(flag4),
      .done_o(done4), .busy_o(busy4));

   bitserial_addsub #(.WIDTH(8)) uut8 (
      .clk(clk), .rst(rst), .start_i(start8), .sub_i(sub8),
      .a_i(a8), .b_i(b8), .result_o(res8), .flag_o(flag8),
      .done_o(done8), .busy_o(busy8));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One WIDTH=4 operation. chained: start already driven at this negedge.
   // noise: drive other starts in every busy cycle. has_next: start next op in done cycle.
   task automatic op4(input int a, input int b, input bit sub, input bit chained,
                      input bit noise, input bit has_next,
                      input int na, input int nb, input bit nsub);
      int sum, exp_res, exp_flag;
      logic [3:0] prev;
      string rq;
      if (sub) begin
         sum = a - b; exp_flag = (a < b) ? 1 : 0; rq = "R2";
      end else begin
         sum = a + b; exp_flag = (sum >> 4) & 1; rq = "R1";
      end
      exp_res = sum & 15;
      if (!chained) begin
         @(negedge clk);
         start4 = 1'b1; a4 = 4'(a); b4 = 4'(b); sub4 = sub;
      end
      @(negedge clk);
      start4 = 1'b0;
      chk(busy4 === 1'b1, "R6 busy after accept", longint'(busy4), 1);
      prev = res4;
      if (noise) begin
         start4 = 1'b1; a4 = ~4'(a); b4 = 4'(b + 7); sub4 = ~sub;
      end
      for (int k = 2; k <= 5; k++) begin
         @(negedge clk);
         chk(done4 === 1'b0, "R3 no early done", longint'(done4), 0);
         chk(res4 === prev, "R4 result frozen", longint'(res4), longint'(prev));
      end
      @(negedge clk);
      start4 = 1'b0;
      chk(done4 === 1'b1, "R3 done at N+1", longint'(done4), 1);
      chk(busy4 === 1'b0, "R6 busy fall with done", longint'(busy4), 0);
      chk(res4 === 4'(exp_res), noise ? "R5 start ignored result" : rq,
          longint'(res4), longint'(exp_res));
      chk(flag4 === 1'(exp_flag), {rq, " flag"}, longint'(flag4), longint'(exp_flag));
      if (has_next) begin
         start4 = 1'b1; a4 = 4'(na); b4 = 4'(nb); sub4 = nsub;
      end else begin
         @(negedge clk);
         chk(done4 === 1'b0, "R3 single pulse", longint'(done4), 0);
      end
   endtask

   task automatic op8(input int a, input int b, input bit sub, input string rq);
      int sum, exp_res, exp_flag;
      if (sub) begin
         sum = a - b; exp_flag = (a < b) ? 1 : 0;
      end else begin
         sum = a + b; exp_flag = (sum >> 8) & 1;
      end
      exp_res = sum & 255;
      @(negedge clk);
      start8 = 1'b1; a8 = 8'(a); b8 = 8'(b); sub8 = sub;
      @(negedge clk);
      start8 = 1'b0;
      for (int k = 2; k <= 9; k++) begin
         @(negedge clk);
         chk(done8 === 1'b0, "R3 no early done w8", longint'(done8), 0);
      end
      @(negedge clk);
      chk(done8 === 1'b1, "R3 done w8", longint'(done8), 1);
      chk(res8 === 8'(exp_res), rq, longint'(res8), longint'(exp_res));
      chk(flag8 === 1'(exp_flag), {rq, " flag"}, longint'(flag8), longint'(exp_flag));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(res4 === 4'd0 && flag4 === 1'b0, "R7 reset result w4", longint'(res4), 0);
      chk(done4 === 1'b0 && busy4 === 1'b0, "R7 reset ctrl w4", longint'(busy4), 0);
      chk(res8 === 8'd0 && flag8 === 1'b0, "R7 reset result w8", longint'(res8), 0);
      rst = 1'b0;

      // R8 reference and carry edges at default width
      op8(8'h55, 8'hAA, 1'b0, "R8 reference");
      op8(255, 1, 1'b0, "R1 w8 wrap");
      op8(0, 1, 1'b1, "R2 w8 borrow");
      op8(200, 73, 1'b1, "R2 w8");

      // R1/R2 exhaustive sweep at WIDTH=4
      for (int s = 0; s < 2; s++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               op4(a, b, 1'(s), 1'b0, 1'b0, 1'b0, 0, 0, 1'b0);

      // R5 starts during busy are ignored
      op4(3, 5, 1'b0, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0);
      op4(2, 9, 1'b1, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0);

      // R9 back-to-back chaining into the done cycle
      op4(15, 15, 1'b0, 1'b0, 1'b0, 1'b1, 4, 11, 1'b1);
      op4(4, 11, 1'b1, 1'b1, 1'b0, 1'b1, 7, 8, 1'b0);
      op4(7, 8, 1'b0, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0);

      if (!ended) begin
         ended = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end
endmodule